// File: doc/BRIEF.md
# Double-Buffered Converter Code Front End

This block is the digital front end of an 8-bit multiplying converter. Two cascaded registers sit between a parallel data bus and the converter code. The first (staging) register takes the bus while a chip select, an input enable and a first write strobe are all asserted together. The second (output) register takes the staging register's word while a second write strobe and a transfer strobe are both asserted. The output register drives a registered code word and its bitwise complement. These model the true and complementary current steering of the converter ladder.

Each register follows its input while its enable combination holds, and keeps its value while that combination is false. There is no mode register. How the strobes are strapped decides the behaviour. With every control asserted, the bus flows through to the code. With the transfer path tied open, the first strobe alone updates the code. Driving the strobes separately gives double-buffered use, and a shared transfer strobe can update several converters at the same moment. All control and data pins are sampled on a fast system clock. A parameter selects between transparent-latch emulation and fully sampled registers. A per-bit mask marks bus pins that are not driven, and the block reads those bits as 1.

Top module: `dbuf_dac_front`

## Requirements
- R1: While reset is asserted, and after it is released with no strobe activity, `code` is 0x00 and `code_n` is 0xFF.
- R2: The staging register follows the bus only while `sel_n`=0, `wen`=1 and `wstb1_n`=0 are all true in the same sampled cycle.
- R3: While `wstb1_n`=1 the staging register holds its contents, whatever the bus and the other controls do.
- R4: While `sel_n`=1 the staging register holds its contents.
- R5: The output register loads the staging register's word only while `wstb2_n`=0 and `xfr_n`=0. If either is 1, it holds.
- R6: With `wen`=0 the staging register is frozen, and bus or strobe activity cannot change it.
- R7: In flow-through strapping (`sel_n`, `wstb1_n`, `wstb2_n`, `xfr_n` all 0 and `wen`=1), a value held on `din` appears on `code` two clock edges after it is first present. In the default transparent mode both registers pass it within the same sampled cycle.
- R8: In single-buffered strapping (`wstb2_n`=`xfr_n`=0, `wen`=1, `sel_n`=0), pulsing `wstb1_n` low updates `code`, and raising it freezes `code`.
- R9: In double-buffered use, `code` keeps the old word while a new one is staged. A later transfer with `wstb1_n`=1 moves the staged word to `code`.
- R10: A `din` bit whose `din_float` bit is 1 is read as logic 1.
- R11: `code` carries the word with bit 0 as LSB and bit 7 as MSB, numerically equal to the loaded value. `code_n` is always its bitwise complement, so a loaded 0xFF gives `code`=0xFF and `code_n`=0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sel_n | input | 1 | Chip select, active low |
| wen | input | 1 | Input enable, active high |
| wstb1_n | input | 1 | First write strobe, active low, qualifies the staging register |
| wstb2_n | input | 1 | Second write strobe, active low, qualifies the output register |
| xfr_n | input | 1 | Transfer strobe, active low |
| din | input | 8 | Data bus, bit 0 is LSB |
| din_float | input | 8 | Per-bit mask, 1 marks an undriven bus pin |
| code | output | 8 | Registered converter code (true steering) |
| code_n | output | 8 | Bitwise complement of `code` (complementary steering) |

## Verification
The assertions assume the controls and data are synchronous to `clk`, or slow enough that one sampling register cannot leave them metastable. They also assume that a sampled level held for one cycle means the strobe was asserted for that cycle. The stimulus changes every pin only on the falling clock edge. It then holds each pin combination for two rising edges before sampling `code`, so each step presents a stable level to both registers. The sweeps cover all 32 control combinations, the full 256-value data range and every single floating bit.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;
  typedef enum logic {
    STAGE_TRANSPARENT = 1'b0,
    STAGE_SAMPLED     = 1'b1
  } stage_kind_e;

  typedef struct packed {
    logic sel_n;
    logic wen;
    logic wstb1_n;
    logic wstb2_n;
    logic xfr_n;
  } ctrl_pins_t;

  localparam ctrl_pins_t CTRL_IDLE = '{sel_n: 1'b1, wen: 1'b0, wstb1_n: 1'b1,
                                       wstb2_n: 1'b1, xfr_n: 1'b1};
endpackage

// File: rtl/dbuf_rst_sync.sv
module dbuf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/dbuf_pin_sample.sv
module dbuf_pin_sample
  import dbuf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_pins_t        ctrl_in,
  input  logic [DATA_W-1:0] bus_in,
  input  logic [DATA_W-1:0] float_in,
  output ctrl_pins_t        ctrl_s,
  output logic [DATA_W-1:0] bus_s
);
  ctrl_pins_t        ctrl_d;
  logic [DATA_W-1:0] bus_d;

  // An undriven pin reads as a high level
  always_comb begin
    ctrl_d = ctrl_in;
    bus_d  = bus_in | float_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_s <= CTRL_IDLE;
      bus_s  <= '0;
    end else begin
      ctrl_s <= ctrl_d;
      bus_s  <= bus_d;
    end
  end
endmodule

// File: rtl/dbuf_stage.sv
module dbuf_stage
  import dbuf_pkg::*;
#(
  parameter int          DATA_W = 8,
  parameter stage_kind_e KIND   = STAGE_TRANSPARENT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              open_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o,
  output logic [DATA_W-1:0] held_o
);
  logic [DATA_W-1:0] held_q;
  logic [DATA_W-1:0] held_d;

  always_comb begin
    held_d = open_i ? d_i : held_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      held_q <= '0;
    else if (open_i) held_q <= held_d;
  end

  generate
    if (KIND == STAGE_TRANSPARENT) begin : g_transp
      assign q_o = open_i ? d_i : held_q;
    end else begin : g_sampled
      assign q_o = held_q;
    end
  endgenerate

  assign held_o = held_q;

  AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !open_i |=> $stable(held_q)) else $error("closed stage changed"); // R3
endmodule

// File: rtl/dbuf_dac_front.sv
module dbuf_dac_front
  import dbuf_pkg::*;
#(
  parameter int          DATA_W     = 8,
  parameter int          RST_STAGES = 2,
  parameter stage_kind_e KIND       = STAGE_TRANSPARENT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              wen,
  input  logic              wstb1_n,
  input  logic              wstb2_n,
  input  logic              xfr_n,
  input  logic [DATA_W-1:0] din,
  input  logic [DATA_W-1:0] din_float,
  output logic [DATA_W-1:0] code,
  output logic [DATA_W-1:0] code_n
);
  localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};

  logic              rst_n_i;
  ctrl_pins_t        ctrl_raw;
  ctrl_pins_t        ctrl_s;
  logic [DATA_W-1:0] bus_s;
  logic              stg_open;
  logic              out_open;
  logic [DATA_W-1:0] stg_q;
  logic [DATA_W-1:0] stg_held;
  logic [DATA_W-1:0] out_q;
  logic [DATA_W-1:0] out_held;
  logic [DATA_W-1:0] code_q;
  logic [DATA_W-1:0] code_n_q;
  logic [DATA_W-1:0] code_d;
  logic [DATA_W-1:0] code_n_d;

  dbuf_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_n_i)
  );

  always_comb begin
    ctrl_raw.sel_n   = sel_n;
    ctrl_raw.wen     = wen;
    ctrl_raw.wstb1_n = wstb1_n;
    ctrl_raw.wstb2_n = wstb2_n;
    ctrl_raw.xfr_n   = xfr_n;
  end

  dbuf_pin_sample #(.DATA_W(DATA_W)) u_pins (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .ctrl_in (ctrl_raw),
    .bus_in  (din),
    .float_in(din_float),
    .ctrl_s  (ctrl_s),
    .bus_s   (bus_s)
  );

  // Staging register qualifier: all three conditions at the same time
  always_comb begin
    stg_open = !ctrl_s.sel_n && ctrl_s.wen && !ctrl_s.wstb1_n;
    out_open = !ctrl_s.wstb2_n && !ctrl_s.xfr_n;
  end

  dbuf_stage #(.DATA_W(DATA_W), .KIND(KIND)) u_stage (
    .clk   (clk),
    .rst_n (rst_n_i),
    .open_i(stg_open),
    .d_i   (bus_s),
    .q_o   (stg_q),
    .held_o(stg_held)
  );

  dbuf_stage #(.DATA_W(DATA_W), .KIND(KIND)) u_out (
    .clk   (clk),
    .rst_n (rst_n_i),
    .open_i(out_open),
    .d_i   (stg_q),
    .q_o   (out_q),
    .held_o(out_held)
  );

  always_comb begin
    code_d   = out_q;
    code_n_d = out_q ^ ALL_ONES;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      code_q   <= '0;
      code_n_q <= ALL_ONES;
    end else begin
      code_q   <= code_d;
      code_n_q <= code_n_d;
    end
  end

  assign code   = code_q;
  assign code_n = code_n_q;

  AST_FREEZE_WEN: assert property (@(posedge clk) disable iff (!rst_n_i)
    !ctrl_s.wen |=> $stable(stg_held)) else $error("frozen staging changed"); // R6

  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n_i)
    ctrl_s.sel_n |=> $stable(stg_held)) else $error("deselected staging changed"); // R4

  AST_XFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n_i)
    (ctrl_s.wstb2_n || ctrl_s.xfr_n) |=> $stable(out_held)) else $error("output reg changed"); // R5

  AST_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n_i)
    (code_q ^ code_n_q) == ALL_ONES) else $error("complement broken"); // R11

  generate
    if (KIND == STAGE_TRANSPARENT) begin : g_flow_chk
      AST_FLOW_SAME: assert property (@(posedge clk) disable iff (!rst_n_i)
        (stg_open && out_open) |=> (code_q == $past(bus_s))) else $error("flow lag"); // R7
    end
  endgenerate
endmodule

// File: tb/dbuf_dac_front_tb.sv
module dbuf_dac_front_tb;
  logic       clk;
  logic       rst_n;
  logic       sel_n, wen, wstb1_n, wstb2_n, xfr_n;
  logic [7:0] din, din_float;
  logic [7:0] code, code_n;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  logic [7:0] m_stg, m_out;

  dbuf_dac_front u_dut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wen(wen), .wstb1_n(wstb1_n),
    .wstb2_n(wstb2_n), .xfr_n(xfr_n), .din(din), .din_float(din_float),
    .code(code), .code_n(code_n)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [7:0] exp);
    total++;
    if (code !== exp || code_n !== ~exp) begin
      bad++;
      $display("FAIL %s: actual code=%h code_n=%h expected code=%h code_n=%h",
               req, code, code_n, exp, ~exp);
    end
  endtask

  // Drive on the falling edge, hold for two rising edges, sample on falling edge
  task automatic apply(input logic s, input logic e, input logic w1, input logic w2,
                       input logic x, input logic [7:0] d, input logic [7:0] f);
    logic [7:0] eff;
    @(negedge clk);
    sel_n = s; wen = e; wstb1_n = w1; wstb2_n = w2; xfr_n = x;
    din = d; din_float = f;
    eff = d | f;
    if (!s && e && !w1) m_stg = eff;
    if (!w2 && !x)      m_out = m_stg;
    @(posedge clk); @(posedge clk); @(negedge clk);
  endtask

  task automatic idle();
    apply(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0;
    sel_n = 1'b1; wen = 1'b0; wstb1_n = 1'b1; wstb2_n = 1'b1; xfr_n = 1'b1;
    din = 8'h00; din_float = 8'h00;
    m_stg = 8'h00; m_out = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 in reset", 8'h00);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1 after release", 8'h00);

    // R7 / R11: flow-through, all 256 codes
    for (int v = 0; v < 256; v++) begin
      apply(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, v[7:0], 8'h00);
      check("R7 R11 flow-through", v[7:0]);
    end

    // R7: exact latency, value visible after two edges not one
    @(negedge clk);
    din = 8'h3C;
    @(posedge clk); @(negedge clk);
    check("R7 one edge still old", 8'hFF);
    @(posedge clk); @(negedge clk);
    check("R7 two edges new", 8'h3C);
    m_stg = 8'h3C; m_out = 8'h3C;

    // R2 R3 R4 R5 R6: every control combination, then expose staging reg
    for (int c = 0; c < 32; c++) begin
      for (int k = 0; k < 3; k++) begin
        logic [7:0] dv;
        dv = 8'(c * 37 + k * 91 + 5);
        apply(c[0], c[1], c[2], c[3], c[4], dv, 8'h00);
        check("R2 R4 R5 control sweep code", m_out);
        apply(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, ~dv, 8'h00);
        check("R3 R6 staging readback", m_stg);
      end
    end

    // R6: wen low freezes staging despite active strobes
    apply(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'hA5, 8'h00);
    apply(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h5A, 8'h00);
    check("R6 frozen by wen", 8'hA5);

    // R8: single-buffered
    apply(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h11, 8'h00);
    check("R8 strobe high holds", 8'hA5);
    apply(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h77, 8'h00);
    check("R8 strobe low updates", 8'h77);
    apply(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h99, 8'h00);
    check("R8 strobe released holds", 8'h77);

    // R9: double-buffered
    apply(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'hC3, 8'h00);
    check("R9 staged, old code", 8'h77);
    apply(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'h00);
    check("R9 waiting", 8'h77);
    apply(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00);
    check("R9 transfer", 8'hC3);

    // R10: each floating bit reads as 1
    for (int b = 0; b < 8; b++) begin
      logic [7:0] msk;
      msk = 8'h01 << b;
      apply(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, msk);
      check("R10 floating bit", msk);
    end
    apply(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'hFF);
    check("R10 R11 all floating full scale", 8'hFF);
    idle();
    check("R11 idle hold", 8'hFF);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule